// File: doc/BRIEF.md
# Banked Pin Mux and GPIO Controller

This block sits between a register bus and a row of pads. Each pad is owned either by the GPIO path or by one of several peripheral function groups. Every group has one enable bit. A pad falls back to GPIO only when no enabled group lists it. Under GPIO ownership, software sets the pad direction and output level. Whatever the owner, software can also select no bias, pull-up or pull-down on each pad. The pad levels always pass through a synchronizer, so software can read them in every mode.

Pins are grouped into banks. Each bank occupies a contiguous run of bits inside shared 32-bit registers. The run starts at a per-bank base bit, so two banks can live in one word at different offsets. An elaboration option moves the pull-enable bits into the pull-direction word. All pad-side outputs are registered.

Top module: `padmux_ctrl`

## Requirements
- R1: After reset, no pad is driven (pad_oe all 0) and no pad is biased (pad_pu and pad_pd all 0). The direction word reads 1 in every pin bit and the mux word reads 0.
- R2: Registers sit on a 4-byte stride, with byte address equal to word index times 4. 0x00 holds the group enables, 0x04 pull enable, 0x08 pull direction, 0x0C GPIO direction, 0x10 GPIO output value, and 0x14 sampled input (read-only). Read data and rvalid appear on the clock edge after rd_en is sampled.
- R3: Pin p maps to bit (p / PINS_PER_BANK) * BANK_STRIDE + p % PINS_PER_BANK of each per-pin word. With the defaults (6 pins per bank, stride 8), pins 0-5 use bits 0-5 and pins 6-11 use bits 8-13.
- R4: A GPIO-owned pin with direction bit 1 is an input (pad_oe 0). With direction bit 0 it drives pad_do from its output-value bit. Pad outputs change one edge after the register write.
- R5: A pin with pull-enable 0 has no bias. With pull-enable 1, a pull-direction bit of 1 asserts pad_pu and a bit of 0 asserts pad_pd. The two are never high together.
- R6: Group g's enable is mux bit g. While an enabled group lists a pin, pad_oe and pad_do follow that group's peripheral inputs, and the GPIO output register has no effect on the pad.
- R7: When several enabled groups list the same pin, the lowest-numbered group owns it. The pin returns to GPIO only once every group that lists it is disabled.
- R8: The input word returns each pad level after a two-flop synchronizer, whatever the pin's direction. Writes to it have no effect.
- R9: A write changes only the bits whose wmask bit is 1.
- R10: Reads from addresses at or above 0x18 return 0, and so do reads from addresses whose low two bits are nonzero. Writes to such addresses change nothing.
- R11: With SHARED_PULL set, pull-enable for a pin sits in the 0x08 word at its mapped bit plus PEN_SHIFT (16 by default), and 0x04 becomes unmapped and reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| wmask | input | 32 | Per-bit write mask |
| rdata | output | 32 | Read data |
| rvalid | output | 1 | Read data valid |
| grp_oe | input | NUM_GROUPS*NUM_PINS | Peripheral output enables, group g pin p at g*NUM_PINS+p |
| grp_do | input | NUM_GROUPS*NUM_PINS | Peripheral output values, same packing |
| pad_di | input | NUM_PINS | Pad input levels |
| pad_oe | output | NUM_PINS | Pad output enable |
| pad_do | output | NUM_PINS | Pad output value |
| pad_pu | output | NUM_PINS | Pull-up enable |
| pad_pd | output | NUM_PINS | Pull-down enable |

## Verification
The hardest case to reach is a pin that two enabled groups both list. It must obey the lower group, then pass to the higher group, and reach GPIO only when the last claim is dropped. The stimulus gives the two overlapping groups different peripheral patterns on the shared pin. It then takes the groups down one at a time and checks the pads after each step. A second instance built with the shared pull layout receives the same bus traffic, so one write to the pull-direction word shows both layouts side by side.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    RG_MUX  = 3'd0,
    RG_PEN  = 3'd1,
    RG_PDIR = 3'd2,
    RG_DIR  = 3'd3,
    RG_OUT  = 3'd4,
    RG_IN   = 3'd5
  } reg_idx_e;

  // bit of pin p inside a per-pin word
  function automatic int pin_pos(input int p, input int per_bank, input int stride);
    return (p / per_bank) * stride + (p % per_bank);
  endfunction
endpackage

// File: rtl/pinctl_sync.sv
module pinctl_sync #(
  parameter int NUM_PINS = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pad_di,
  output logic [NUM_PINS-1:0] sync_out
);
  logic [NUM_PINS-1:0] stage1;
  logic [1:0]          settle;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        stage1[p]   <= 1'b0;
        sync_out[p] <= 1'b0;
      end else begin
        stage1[p]   <= pad_di[p];
        sync_out[p] <= stage1[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) settle <= 2'd0;
    else if (settle != 2'd3) settle <= settle + 2'd1;
  end

  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (rst)
    (settle >= 2'd2) |-> (sync_out == $past(pad_di, 2))); // R8
endmodule

// File: rtl/pinctl_regs.sv
module pinctl_regs #(
  parameter int NUM_PINS    = 12,
  parameter int NUM_GROUPS  = 4,
  parameter int PER_BANK    = 6,
  parameter int STRIDE      = 8,
  parameter bit SHARED_PULL = 1'b0,
  parameter int PEN_SHIFT   = 16,
  parameter int ADDR_W      = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [31:0]           wdata,
  input  logic [31:0]           wmask,
  input  logic [NUM_PINS-1:0]   sync_in,
  output logic [31:0]           rdata,
  output logic                  rvalid,
  output logic [NUM_GROUPS-1:0] mux_en,
  output logic [NUM_PINS-1:0]   pen,
  output logic [NUM_PINS-1:0]   pdir,
  output logic [NUM_PINS-1:0]   dir,
  output logic [NUM_PINS-1:0]   dout
);
  import pinctl_pkg::*;
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic aligned, hit_mux, hit_pen, hit_pdir, hit_dir, hit_out, hit_in, pen_hit, mapped;
  logic [31:0] w_mux, w_pen, w_pdir, w_dir, w_out, w_in, rd_word;

  function automatic int pbit(input int p);
    return pin_pos(p, PER_BANK, STRIDE);
  endfunction

  function automatic int ebit(input int p);
    return SHARED_PULL ? pin_pos(p, PER_BANK, STRIDE) + PEN_SHIFT : pin_pos(p, PER_BANK, STRIDE);
  endfunction

  assign word     = addr[ADDR_W-1:2];
  assign aligned  = (addr[1:0] == 2'b00);
  assign hit_mux  = aligned && (word == WORD_W'(RG_MUX));
  assign hit_pen  = aligned && (word == WORD_W'(RG_PEN)) && !SHARED_PULL;
  assign hit_pdir = aligned && (word == WORD_W'(RG_PDIR));
  assign hit_dir  = aligned && (word == WORD_W'(RG_DIR));
  assign hit_out  = aligned && (word == WORD_W'(RG_OUT));
  assign hit_in   = aligned && (word == WORD_W'(RG_IN));
  assign pen_hit  = SHARED_PULL ? hit_pdir : hit_pen;
  assign mapped   = hit_mux | hit_pen | hit_pdir | hit_dir | hit_out | hit_in;

  // register state, written under per-bit mask
  always_ff @(posedge clk) begin
    if (rst) begin
      mux_en <= '0;
      pen    <= '0;
      pdir   <= '0;
      dir    <= '1;
      dout   <= '0;
    end else if (wr_en) begin
      for (int g = 0; g < NUM_GROUPS; g++)
        if (hit_mux && wmask[g]) mux_en[g] <= wdata[g];
      for (int p = 0; p < NUM_PINS; p++) begin
        if (hit_dir  && wmask[pbit(p)]) dir[p]  <= wdata[pbit(p)];
        if (hit_out  && wmask[pbit(p)]) dout[p] <= wdata[pbit(p)];
        if (hit_pdir && wmask[pbit(p)]) pdir[p] <= wdata[pbit(p)];
        if (pen_hit  && wmask[ebit(p)]) pen[p]  <= wdata[ebit(p)];
      end
    end
  end

  // readback words
  always_comb begin
    w_mux  = '0;
    w_pen  = '0;
    w_pdir = '0;
    w_dir  = '0;
    w_out  = '0;
    w_in   = '0;
    for (int g = 0; g < NUM_GROUPS; g++) w_mux[g] = mux_en[g];
    for (int p = 0; p < NUM_PINS; p++) begin
      w_dir[pbit(p)]  = dir[p];
      w_out[pbit(p)]  = dout[p];
      w_in[pbit(p)]   = sync_in[p];
      w_pdir[pbit(p)] = pdir[p];
      if (SHARED_PULL) w_pdir[ebit(p)] = pen[p];
      else             w_pen[ebit(p)]  = pen[p];
    end
  end

  always_comb begin
    rd_word = '0;
    if (hit_mux)  rd_word = w_mux;
    if (hit_pen)  rd_word = w_pen;
    if (hit_pdir) rd_word = w_pdir;
    if (hit_dir)  rd_word = w_dir;
    if (hit_out)  rd_word = w_out;
    if (hit_in)   rd_word = w_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_word;
    end
  end

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid); // R2
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !mapped) |=> (rdata == 32'd0)); // R10
  AST_MASK_KEEPS_BIT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit_dir && !wmask[pbit(0)]) |=> $stable(dir[0])); // R9
  AST_INPUT_READONLY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit_in) |=> ($stable(dir) && $stable(dout) && $stable(pdir) && $stable(pen))); // R8
endmodule

// File: rtl/pinctl_route.sv
module pinctl_route #(
  parameter int NUM_PINS   = 12,
  parameter int NUM_GROUPS = 4,
  parameter logic [NUM_GROUPS*NUM_PINS-1:0] GROUP_PINS = '0
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_GROUPS-1:0]          mux_en,
  input  logic [NUM_PINS-1:0]            pen,
  input  logic [NUM_PINS-1:0]            pdir,
  input  logic [NUM_PINS-1:0]            dir,
  input  logic [NUM_PINS-1:0]            dout,
  input  logic [NUM_GROUPS*NUM_PINS-1:0] grp_oe,
  input  logic [NUM_GROUPS*NUM_PINS-1:0] grp_do,
  output logic [NUM_PINS-1:0]            pad_oe,
  output logic [NUM_PINS-1:0]            pad_do,
  output logic [NUM_PINS-1:0]            pad_pu,
  output logic [NUM_PINS-1:0]            pad_pd
);
  logic [NUM_PINS-1:0] nxt_oe, nxt_do;

  // highest group visited first so the lowest enabled group wins
  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      nxt_oe[p] = ~dir[p];
      nxt_do[p] = dout[p];
      for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
        if (mux_en[g] && GROUP_PINS[g*NUM_PINS+p]) begin
          nxt_oe[p] = grp_oe[g*NUM_PINS+p];
          nxt_do[p] = grp_do[g*NUM_PINS+p];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_oe <= '0;
      pad_do <= '0;
      pad_pu <= '0;
      pad_pd <= '0;
    end else begin
      pad_oe <= nxt_oe;
      pad_do <= nxt_do;
      pad_pu <= pen & pdir;
      pad_pd <= pen & ~pdir;
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
    AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
      !(pad_pu[p] && pad_pd[p])); // R5
    if (GROUP_PINS[p]) begin : g_grp0
      AST_GROUP0_OWNS: assert property (@(posedge clk) disable iff (rst)
        mux_en[0] |=> (pad_oe[p] == $past(grp_oe[p]))); // R7
    end
  end
endmodule

// File: rtl/padmux_ctrl.sv
module padmux_ctrl #(
  parameter int NUM_BANKS     = 2,
  parameter int PINS_PER_BANK = 6,
  parameter int BANK_STRIDE   = 8,
  parameter int NUM_GROUPS    = 4,
  parameter bit SHARED_PULL   = 1'b0,
  parameter int PEN_SHIFT     = 16,
  parameter int ADDR_W        = 8,
  parameter int NUM_PINS      = NUM_BANKS * PINS_PER_BANK,
  parameter logic [NUM_GROUPS*NUM_PINS-1:0] GROUP_PINS = 48'hF80_0C0_00E_003
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic                           rd_en,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [31:0]                    wdata,
  input  logic [31:0]                    wmask,
  output logic [31:0]                    rdata,
  output logic                           rvalid,
  input  logic [NUM_GROUPS*NUM_PINS-1:0] grp_oe,
  input  logic [NUM_GROUPS*NUM_PINS-1:0] grp_do,
  input  logic [NUM_PINS-1:0]            pad_di,
  output logic [NUM_PINS-1:0]            pad_oe,
  output logic [NUM_PINS-1:0]            pad_do,
  output logic [NUM_PINS-1:0]            pad_pu,
  output logic [NUM_PINS-1:0]            pad_pd
);
  logic [NUM_PINS-1:0]   sync_in, pen, pdir, dir, dout;
  logic [NUM_GROUPS-1:0] mux_en;

  pinctl_sync #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk(clk), .rst(rst), .pad_di(pad_di), .sync_out(sync_in)
  );

  pinctl_regs #(
    .NUM_PINS(NUM_PINS), .NUM_GROUPS(NUM_GROUPS), .PER_BANK(PINS_PER_BANK),
    .STRIDE(BANK_STRIDE), .SHARED_PULL(SHARED_PULL), .PEN_SHIFT(PEN_SHIFT), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .wmask(wmask), .sync_in(sync_in), .rdata(rdata), .rvalid(rvalid),
    .mux_en(mux_en), .pen(pen), .pdir(pdir), .dir(dir), .dout(dout)
  );

  pinctl_route #(
    .NUM_PINS(NUM_PINS), .NUM_GROUPS(NUM_GROUPS), .GROUP_PINS(GROUP_PINS)
  ) u_route (
    .clk(clk), .rst(rst), .mux_en(mux_en), .pen(pen), .pdir(pdir), .dir(dir),
    .dout(dout), .grp_oe(grp_oe), .grp_do(grp_do),
    .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu), .pad_pd(pad_pd)
  );

  AST_RESET_PADS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pad_oe == '0 && pad_pu == '0 && pad_pd == '0)); // R1
endmodule

// File: tb/sim_padmux_ctrl.sv
module sim_padmux_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, wmask = '0;
  logic [47:0] grp_oe = '0, grp_do = '0;
  logic [11:0] pad_di = '0;
  logic [31:0] rdata0, rdata1;
  logic        rvalid0, rvalid1;
  logic [11:0] oe0, do0, pu0, pd0, oe1, do1, pu1, pd1;

  int n_run = 0, n_fail = 0, cyc = 0;
  logic [31:0] exp_q[$];
  int          dev_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  padmux_ctrl u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .wmask(wmask), .rdata(rdata0), .rvalid(rvalid0), .grp_oe(grp_oe), .grp_do(grp_do),
    .pad_di(pad_di), .pad_oe(oe0), .pad_do(do0), .pad_pu(pu0), .pad_pd(pd0)
  );

  padmux_ctrl #(.SHARED_PULL(1'b1)) u1 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .wmask(wmask), .rdata(rdata1), .rvalid(rvalid1), .grp_oe(grp_oe), .grp_do(grp_do),
    .pad_di(pad_di), .pad_oe(oe1), .pad_do(do1), .pad_pu(pu1), .pad_pd(pd1)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rvalid0) begin
      if (exp_q.size() == 0) chk("R2 unexpected rvalid", 32'd1, 32'd0);
      else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic int          d = dev_q.pop_front();
        automatic string       t = tag_q.pop_front();
        chk(t, (d == 0) ? rdata0 : rdata1, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected < 20000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic [31:0] m);
    @(negedge clk);
    addr = a; wdata = d; wmask = m; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk); // pads registered one edge after the register
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [31:0] e, input int dev, input string tag);
    exp_q.push_back(e); dev_q.push_back(dev); tag_q.push_back(tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pad_oe", 32'(oe0), 32'h0);
    chk("R1 pad_pu", 32'(pu0), 32'h0);
    chk("R1 pad_pd", 32'(pd0), 32'h0);
    bus_rd(8'h0C, 32'h0000_3F3F, 0, "R1 R3 dir reset");
    bus_rd(8'h00, 32'h0, 0, "R1 mux reset");

    // R11 shared pull layout in u1
    bus_wr(8'h08, 32'h0001_0001, 32'hFFFF_FFFF);
    chk("R11 shared pull-up", 32'(pu1), 32'h001);
    chk("R11 separate layout unbiased", 32'(pu0), 32'h000);
    bus_rd(8'h08, 32'h0001_0001, 1, "R11 shared readback");
    bus_rd(8'h04, 32'h0, 1, "R11 pen word unmapped");
    bus_wr(8'h08, 32'h0, 32'hFFFF_FFFF);

    // R4 R3 direction and output of pin 6 (bit 8)
    bus_wr(8'h0C, 32'h0, 32'h0000_0100);
    bus_wr(8'h10, 32'h100, 32'h0000_0100);
    chk("R4 R3 pin6 oe", 32'(oe0), 32'h040);
    chk("R4 pin6 do", 32'(do0), 32'h040);

    // R9 masked write to pin 0 only
    bus_wr(8'h0C, 32'h0, 32'h0000_0001);
    chk("R9 neighbour kept", 32'(oe0), 32'h041);
    bus_rd(8'h0C, 32'h0000_3E3E, 0, "R9 dir readback");

    // R5 pulls: pin1 up, pin2 down
    bus_wr(8'h04, 32'h6, 32'hFFFF_FFFF);
    bus_wr(8'h08, 32'h2, 32'hFFFF_FFFF);
    chk("R5 pull-up", 32'(pu0), 32'h002);
    chk("R5 pull-down", 32'(pd0), 32'h004);

    // R6 group 0 owns pins 0,1
    grp_oe = {12'h0, 12'h0, 12'h004, 12'h003};
    grp_do = {12'h0, 12'h0, 12'h00E, 12'h000};
    bus_wr(8'h00, 32'h1, 32'hFFFF_FFFF);
    bus_wr(8'h10, 32'h1, 32'h0000_0001);
    chk("R6 group oe", 32'(oe0), 32'h043);
    chk("R6 gpio out ignored", 32'(do0), 32'h040);

    // R7 overlap on pin1
    bus_wr(8'h00, 32'h3, 32'hFFFF_FFFF);
    chk("R7 both oe", 32'(oe0), 32'h047);
    chk("R7 lowest wins do", 32'(do0), 32'h04C);
    bus_wr(8'h00, 32'h2, 32'hFFFF_FFFF);
    chk("R7 group1 takes pin1 oe", 32'(oe0), 32'h045);
    chk("R7 group1 takes pin1 do", 32'(do0), 32'h04F);
    bus_wr(8'h00, 32'h0, 32'hFFFF_FFFF);
    chk("R7 all gpio oe", 32'(oe0), 32'h041);
    chk("R7 all gpio do", 32'(do0), 32'h041);

    // R8 synchronized input, read-only
    pad_di = 12'hA5A;
    repeat (3) @(negedge clk);
    bus_rd(8'h14, 32'h0000_291A, 0, "R8 input sampled");
    bus_wr(8'h14, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    bus_rd(8'h14, 32'h0000_291A, 0, "R8 input not writable");
    pad_di = 12'h000;
    repeat (3) @(negedge clk);
    bus_rd(8'h14, 32'h0, 0, "R8 input low");

    // R10 unmapped and misaligned
    bus_rd(8'h18, 32'h0, 0, "R10 beyond map");
    bus_rd(8'h0D, 32'h0, 0, "R10 misaligned read");
    bus_wr(8'h0D, 32'h0, 32'hFFFF_FFFF);
    bus_rd(8'h0C, 32'h0000_3E3E, 0, "R10 misaligned write ignored");

    // R2 map readback
    bus_rd(8'h10, 32'h0000_0101, 0, "R2 out word");
    bus_rd(8'h08, 32'h2, 0, "R2 pdir word");
    bus_rd(8'h04, 32'h6, 0, "R2 pen word");

    repeat (3) @(negedge clk);
    chk("R2 all reads returned", 32'(exp_q.size()), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule